// File: doc/BRIEF.md
# Configurable Multiply-Add Accumulator Slice

This slice multiplies four pairs of 18-bit operands, folds the four products into two partial results with two first-stage adders, and combines those partials in one 44-bit second-stage adder. The second-stage adder is fixed at build time to one of three behaviours. It can produce the plain sum of the four products. It can add that sum to a running 44-bit total. Or it can add the sum to a 44-bit value passed in from a neighbouring slice.

Operands, sign controls and side-band controls are captured in an input register. An optional pipeline register can sit between the first-stage and second-stage adders. The result is held in an output register, which also drives the chain-out bus. A valid flag travels with the data through every stage, so a downstream consumer, or the next slice in a cascade, knows when a result is fresh.

Top module: `mac_slice`

## Requirements
- R1: Each A operand is two's complement when `signa_i`=1 and zero-extended when `signa_i`=0. B operands follow `signb_i` in the same way. A product is signed whenever either control is 1.
- R2: With both sign controls at 0, every product is the unsigned product of its operands, zero-extended to 44 bits.
- R3: First-stage adder k combines products 2k and 2k+1. When bit k of the static mask `SUB_MASK` is 1 it computes product 2k minus product 2k+1, and otherwise their sum. The mask has no runtime control.
- R4: When `MODE`=MODE_SUM4, the result is the sum of the two first-stage outputs, taken modulo 2^44.
- R5: When `MODE`=MODE_ACCUM, each valid item adds its sum to the held total, wrapping modulo 2^44 with no saturation.
- R6: In MODE_ACCUM, a valid item with `clr_i`=1 replaces the total with that item's own sum.
- R7: When `MODE`=MODE_CHAIN, the result is the item's sum plus `chain_i`, modulo 2^44. `chain_i` is sampled in the same cycle as the operands.
- R8: `valid_o` rises exactly 2 cycles after an item is accepted with `valid_i`=1 when `PIPE_EN`=0, and exactly 3 cycles after when `PIPE_EN`=1. Items may arrive every cycle.
- R9: A cycle with `valid_i`=0 produces no `valid_o` pulse and leaves `result_o` and the running total unchanged, whatever the other inputs carry.
- R10: `chain_o` always equals `result_o`, so it is a registered value.
- R11: After reset, `result_o`, `chain_o` and `valid_o` are 0.
- R12: `clr_i` has no effect outside MODE_ACCUM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operands and controls are valid this cycle |
| a_i | input | N_MUL*A_W | A operands; operand k occupies bits [k*A_W +: A_W] |
| b_i | input | N_MUL*B_W | B operands, packed the same way |
| signa_i | input | 1 | 1 = A operands signed, 0 = unsigned |
| signb_i | input | 1 | 1 = B operands signed, 0 = unsigned |
| clr_i | input | 1 | Restart the accumulation with this item (MODE_ACCUM only) |
| chain_i | input | ACC_W | Value from a neighbouring slice, added in MODE_CHAIN |
| result_o | output | ACC_W | Registered result |
| chain_o | output | ACC_W | Copy of the registered result for the next slice |
| valid_o | output | 1 | Result updated this cycle |

## Verification
Each result is due 2 cycles after its operands are accepted when the pipeline stage is off, and 3 cycles after when it is on. The bench runs three instances side by side, one per mode, and they use both latencies. Every driven item goes into a queue stamped with the cycle in which its result must appear. The monitor samples on the falling edge. A result that arrives earlier, later, or with no matching item is reported against R8. Between results, the monitor checks that the output holds its last value.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;
  typedef enum logic [1:0] {
    MODE_SUM4  = 2'd0,
    MODE_ACCUM = 2'd1,
    MODE_CHAIN = 2'd2
  } acc_mode_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int A_W   = 18,
  parameter int B_W   = 18,
  parameter int OUT_W = 44
) (
  input  logic [A_W-1:0]   a_i,
  input  logic [B_W-1:0]   b_i,
  input  logic             signa_i,
  input  logic             signb_i,
  output logic [OUT_W-1:0] p_o
);
  localparam int PW = A_W + B_W + 2;

  logic signed [A_W:0]  a_x;
  logic signed [B_W:0]  b_x;
  logic signed [PW-1:0] prod;

  // one guard bit per operand: zero for unsigned, sign copy for signed
  assign a_x  = {signa_i & a_i[A_W-1], a_i};
  assign b_x  = {signb_i & b_i[B_W-1], b_i};
  assign prod = a_x * b_x;
  assign p_o  = {{(OUT_W-PW){prod[PW-1]}}, prod};
endmodule

// File: rtl/mac_pair_add.sv
module mac_pair_add #(
  parameter int W   = 44,
  parameter bit SUB = 1'b0
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] s_o
);
  if (SUB) begin : g_sub
    assign s_o = x_i - y_i;
  end else begin : g_add
    assign s_o = x_i + y_i;
  end
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
  import mac_slice_pkg::*;
#(
  parameter int        W    = 44,
  parameter acc_mode_e MODE = MODE_SUM4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         clr_i,
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] chain_i,
  output logic [W-1:0] res_o,
  output logic         valid_o
);
  logic [W-1:0] res_q;
  logic [W-1:0] res_d;

  always_comb begin
    case (MODE)
      MODE_ACCUM: res_d = clr_i ? sum_i : res_q + sum_i;
      MODE_CHAIN: res_d = sum_i + chain_i;
      default:    res_d = sum_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int               A_W      = 18,
  parameter int               B_W      = 18,
  parameter int               N_MUL    = 4,
  parameter int               ACC_W    = 44,
  parameter bit               PIPE_EN  = 1'b1,
  parameter logic [N_MUL/2-1:0] SUB_MASK = '0,
  parameter acc_mode_e        MODE     = MODE_SUM4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [N_MUL*A_W-1:0] a_i,
  input  logic [N_MUL*B_W-1:0] b_i,
  input  logic                 signa_i,
  input  logic                 signb_i,
  input  logic                 clr_i,
  input  logic [ACC_W-1:0]     chain_i,
  output logic [ACC_W-1:0]     result_o,
  output logic [ACC_W-1:0]     chain_o,
  output logic                 valid_o
);
  localparam int N_PAIR = N_MUL / 2;

  // input register stage
  logic [N_MUL*A_W-1:0] a_q;
  logic [N_MUL*B_W-1:0] b_q;
  logic                 sa_q, sb_q, clr_q, v_q;
  logic [ACC_W-1:0]     chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      sa_q    <= 1'b0;
      sb_q    <= 1'b0;
      clr_q   <= 1'b0;
      v_q     <= 1'b0;
      chain_q <= '0;
    end else begin
      v_q <= valid_i;
      if (valid_i) begin
        a_q     <= a_i;
        b_q     <= b_i;
        sa_q    <= signa_i;
        sb_q    <= signb_i;
        clr_q   <= clr_i;
        chain_q <= chain_i;
      end
    end
  end

  // multipliers and first-stage adders
  logic [ACC_W-1:0] prod   [N_MUL];
  logic [ACC_W-1:0] part_1 [N_PAIR];

  for (genvar k = 0; k < N_MUL; k++) begin : g_mul
    mac_mult #(.A_W(A_W), .B_W(B_W), .OUT_W(ACC_W)) u_mul (
      .a_i     (a_q[k*A_W +: A_W]),
      .b_i     (b_q[k*B_W +: B_W]),
      .signa_i (sa_q),
      .signb_i (sb_q),
      .p_o     (prod[k])
    );
  end

  for (genvar j = 0; j < N_PAIR; j++) begin : g_pair
    mac_pair_add #(.W(ACC_W), .SUB(SUB_MASK[j])) u_add (
      .x_i (prod[2*j]),
      .y_i (prod[2*j+1]),
      .s_o (part_1[j])
    );
  end

  // optional pipeline stage between first and second adders
  logic [ACC_W-1:0] part_2 [N_PAIR];
  logic [ACC_W-1:0] chain_2;
  logic             v_2, clr_2;

  if (PIPE_EN) begin : g_pipe
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int j = 0; j < N_PAIR; j++) part_2[j] <= '0;
        chain_2 <= '0;
        v_2     <= 1'b0;
        clr_2   <= 1'b0;
      end else begin
        v_2 <= v_q;
        if (v_q) begin
          for (int j = 0; j < N_PAIR; j++) part_2[j] <= part_1[j];
          chain_2 <= chain_q;
          clr_2   <= clr_q;
        end
      end
    end
  end else begin : g_nopipe
    always_comb begin
      for (int j = 0; j < N_PAIR; j++) part_2[j] = part_1[j];
    end
    assign chain_2 = chain_q;
    assign v_2     = v_q;
    assign clr_2   = clr_q;
  end

  // second-stage adder
  logic [ACC_W-1:0] sum_2;

  always_comb begin
    sum_2 = '0;
    for (int j = 0; j < N_PAIR; j++) sum_2 = sum_2 + part_2[j];
  end

  mac_acc_stage #(.W(ACC_W), .MODE(MODE)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (v_2),
    .clr_i   (clr_2),
    .sum_i   (sum_2),
    .chain_i (chain_2),
    .res_o   (result_o),
    .valid_o (valid_o)
  );

  assign chain_o = result_o;
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk
  import mac_slice_pkg::*;
#(
  parameter int        A_W     = 18,
  parameter int        B_W     = 18,
  parameter int        ACC_W   = 44,
  parameter bit        PIPE_EN = 1'b1,
  parameter acc_mode_e MODE    = MODE_SUM4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             valid_o,
  input logic [ACC_W-1:0] result_o,
  input logic             s2_valid,
  input logic             s2_clr,
  input logic [ACC_W-1:0] s2_sum,
  input logic [ACC_W-1:0] s2_chain,
  input logic             sa_q,
  input logic             sb_q,
  input logic [ACC_W-1:0] p0
);
  localparam int LAT = PIPE_EN ? 3 : 2;

  logic [1:0] since_rst;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(since_rst) >= LAT) |-> (valid_o == $past(valid_i, LAT)));

  a_r2_unsigned_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sa_q && !sb_q) |-> (p0[ACC_W-1:A_W+B_W] == '0));

  a_r4_sum4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == MODE_SUM4 && s2_valid) |=> (result_o == $past(s2_sum)));

  a_r5_accum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == MODE_ACCUM && s2_valid && !s2_clr)
      |=> (result_o == $past(result_o) + $past(s2_sum)));

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == MODE_ACCUM && s2_valid && s2_clr) |=> (result_o == $past(s2_sum)));

  a_r7_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == MODE_CHAIN && s2_valid)
      |=> (result_o == $past(s2_sum) + $past(s2_chain)));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s2_valid |=> ($stable(result_o) && !valid_o));
endmodule

bind mac_slice mac_slice_chk #(
  .A_W(A_W), .B_W(B_W), .ACC_W(ACC_W), .PIPE_EN(PIPE_EN), .MODE(MODE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .s2_valid (v_2),
  .s2_clr   (clr_2),
  .s2_sum   (sum_2),
  .s2_chain (chain_2),
  .sa_q     (sa_q),
  .sb_q     (sb_q),
  .p0       (prod[0])
);

// File: tb/mac_slice_tb_top.sv
`timescale 1ns/1ps
module mac_slice_tb_top;
  import mac_slice_pkg::*;

  typedef struct {
    logic [43:0] val;
    int          due;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [71:0] a_i = '0;
  logic [71:0] b_i = '0;
  logic        signa_i = 1'b0;
  logic        signb_i = 1'b0;
  logic        clr_i = 1'b0;
  logic [43:0] chain_i = '0;

  logic [43:0] res [3];
  logic [43:0] cho [3];
  logic        vo  [3];

  int    cyc = 0;
  int    nchk = 0;
  int    nfail = 0;
  bit    done = 1'b0;
  item_t scb [3][$];
  logic [43:0] last [3];
  logic [43:0] acc_model = '0;

  localparam int LAT [3] = '{3, 2, 3};
  localparam logic [1:0] SUBM [3] = '{2'b10, 2'b00, 2'b01};

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mac_slice #(.PIPE_EN(1'b1), .SUB_MASK(2'b10), .MODE(MODE_SUM4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .signa_i(signa_i), .signb_i(signb_i), .clr_i(clr_i), .chain_i(chain_i),
    .result_o(res[0]), .chain_o(cho[0]), .valid_o(vo[0]));

  mac_slice #(.PIPE_EN(1'b0), .SUB_MASK(2'b00), .MODE(MODE_ACCUM)) dut_acc_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .signa_i(signa_i), .signb_i(signb_i), .clr_i(clr_i), .chain_i(chain_i),
    .result_o(res[1]), .chain_o(cho[1]), .valid_o(vo[1]));

  mac_slice #(.PIPE_EN(1'b1), .SUB_MASK(2'b01), .MODE(MODE_CHAIN)) dut_chn_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .signa_i(signa_i), .signb_i(signb_i), .clr_i(clr_i), .chain_i(chain_i),
    .result_o(res[2]), .chain_o(cho[2]), .valid_o(vo[2]));

  function automatic longint opv(logic [17:0] x, logic s);
    return s ? longint'($signed(x)) : longint'({46'b0, x});
  endfunction

  function automatic logic [43:0] esum(logic [71:0] a, logic [71:0] b,
                                       logic sa, logic sb, logic [1:0] sub);
    longint p [4];
    longint t = 0;
    for (int k = 0; k < 4; k++) p[k] = opv(a[k*18 +: 18], sa) * opv(b[k*18 +: 18], sb);
    for (int j = 0; j < 2; j++) t += sub[j] ? p[2*j] - p[2*j+1] : p[2*j] + p[2*j+1];
    return t[43:0];
  endfunction

  task automatic fail(string msg);
    nfail++;
    $display("FAIL %s", msg);
  endtask

  task automatic drive(logic [71:0] a, logic [71:0] b, logic sa, logic sb,
                       logic clr, logic [43:0] ch, string tag);
    logic [43:0] s;
    item_t it;
    @(negedge clk);
    a_i = a; b_i = b; signa_i = sa; signb_i = sb; clr_i = clr; chain_i = ch;
    valid_i = 1'b1;
    for (int d = 0; d < 3; d++) begin
      s = esum(a, b, sa, sb, SUBM[d]);
      if (d == 1) begin
        acc_model = clr ? s : acc_model + s;
        s = acc_model;
      end else if (d == 2) begin
        s = s + ch;
      end
      it.val = s;
      it.due = cyc + LAT[d];
      it.tag = tag;
      scb[d].push_back(it);
    end
  endtask

  task automatic idle(int n, bit noise);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      if (noise) begin
        a_i = {$urandom, $urandom, $urandom};
        b_i = {$urandom, $urandom, $urandom};
        signa_i = $urandom; signb_i = $urandom; clr_i = 1'b1;
        chain_i = {$urandom, $urandom};
      end
    end
  endtask

  task automatic mon(int d);
    item_t it;
    if (vo[d]) begin
      if (scb[d].size() == 0) begin
        nchk++;
        fail($sformatf("R8 dut%0d spurious valid_o actual=1 expected=0", d));
      end else begin
        it = scb[d].pop_front();
        nchk++;
        if (res[d] !== it.val)
          fail($sformatf("%s dut%0d result actual=%h expected=%h", it.tag, d, res[d], it.val));
        nchk++;
        if (cyc != it.due)
          fail($sformatf("R8 dut%0d due cycle actual=%0d expected=%0d", d, cyc, it.due));
        nchk++;
        if (cho[d] !== res[d])
          fail($sformatf("R10 dut%0d chain_o actual=%h expected=%h", d, cho[d], res[d]));
      end
      last[d] = res[d];
    end else begin
      nchk++;
      if (res[d] !== last[d])
        fail($sformatf("R9 dut%0d held result actual=%h expected=%h", d, res[d], last[d]));
      if (scb[d].size() > 0 && scb[d][0].due <= cyc) begin
        it = scb[d].pop_front();
        nchk++;
        fail($sformatf("R8 dut%0d missing valid_o at cycle %0d actual=0 expected=1", d, it.due));
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) for (int d = 0; d < 3; d++) mon(d);
  end

  initial begin
    for (int d = 0; d < 3; d++) last[d] = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    for (int d = 0; d < 3; d++) begin
      nchk++;
      if (vo[d] !== 1'b0 || res[d] !== '0 || cho[d] !== '0)
        fail($sformatf("R11 dut%0d reset actual=%b/%h expected=0/0", d, vo[d], res[d]));
    end
    rst_n = 1'b1;
    idle(2, 1'b0);

    // R2 unsigned max operands, clr ignored in sum/chain modes (R12)
    drive({4{18'h3FFFF}}, {4{18'h3FFFF}}, 1'b0, 1'b0, 1'b1, 44'h0, "R2/R12");
    // R1 both signed: (-1)*(-1)
    drive({4{18'h3FFFF}}, {4{18'h3FFFF}}, 1'b1, 1'b1, 1'b0, 44'h0, "R1");
    // R1 A signed only: (-1)*2
    drive({4{18'h3FFFF}}, {4{18'h00002}}, 1'b1, 1'b0, 1'b0, 44'h5, "R1");
    // R1 B signed only, distinct operands per lane (R3 ordering)
    drive({18'd4, 18'd3, 18'd2, 18'd1}, {18'h3FFFD, 18'h3FFFE, 18'd7, 18'd9},
          1'b0, 1'b1, 1'b0, 44'h0, "R1/R3");
    // R1 most negative squared
    drive({4{18'h20000}}, {4{18'h20000}}, 1'b1, 1'b1, 1'b0, 44'h0, "R1");
    // R9: noise with valid low
    idle(6, 1'b1);
    drive({18'd10, 18'd20, 18'd30, 18'd40}, {18'd1, 18'd2, 18'd3, 18'd4},
          1'b0, 1'b0, 1'b0, 44'h0, "R9/R5/R3");
    // R7 chain wrap
    drive({18'd0, 18'd0, 18'd0, 18'd3}, {4{18'd1}}, 1'b0, 1'b0, 1'b0,
          44'hFFF_FFFF_FFFF, "R7");
    // R6 clear then R5 wrap through back-to-back accumulation
    drive({4{18'h3FFFF}}, {4{18'h3FFFF}}, 1'b0, 1'b0, 1'b1, 44'h0, "R6");
    for (int i = 0; i < 80; i++)
      drive({4{18'h3FFFF}}, {4{18'h3FFFF}}, 1'b0, 1'b0, 1'b0, 44'h0, "R5/R4");
    drive({4{18'd5}}, {4{18'd6}}, 1'b0, 1'b0, 1'b1, 44'h0, "R6");
    idle(3, 1'b0);
    // mixed traffic with gaps
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 4 == 0) idle(1 + $urandom % 3, 1'b1);
      drive({$urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom},
            1'($urandom), 1'($urandom), 1'($urandom % 8 == 0),
            {$urandom, $urandom}, "R4/R5/R7");
    end
    idle(8, 1'b0);
    for (int d = 0; d < 3; d++) begin
      nchk++;
      if (scb[d].size() != 0)
        fail($sformatf("R8 dut%0d pending items actual=%0d expected=0", d, scb[d].size()));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      done = 1'b1;
      nchk++;
      fail("watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule